// File: doc/BRIEF.md
# Load-Store Queue with Exact-Match Store Forwarding

This block sits beside one core's execution pipeline and holds its in-flight memory micro-operations. Loads and stores are allocated in program order into a circular queue of slots; the slot index is returned as the operation's tag. Address generation later supplies each operation's address, plus the data for a store. The queue then sends operations to memory one per cycle, always taking the oldest one that the ordering rules allow. Load results go back to the pipeline on a single writeback port.

The ordering rules are fixed. Loads may go to memory in any order among themselves, and a store may go ahead of older loads. Stores always go out strictly in program order. A load that finds an older, still-unsent store with exactly the same address and the same size takes that store's data directly from the queue. It writes back without a memory access and without waiting for the store. A load that only partly overlaps an older unsent store waits until that store has been sent. A mispredicted path is removed by trimming the tail back to a given tag.

Top module: `lsq_core`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0, `alloc_ready`=1), and neither `mem_req_valid` nor `wb_valid` is asserted.
- R2: Allocation hands out consecutive slot tags, starting at 0 after reset. After DEPTH (16) allocations without retirement, `full`=1 and `alloc_ready`=0, and an allocation attempt while full is ignored: exactly DEPTH results later come back.
- R3: A load whose address is known, with an older unsent store of identical address and identical size (size code s means 2^s bytes), writes back in the following way. It takes the store's data masked to its low 8·2^s bits, with `wb_fwd`=1, and it never issues a memory request.
- R4: When several older unsent stores match a load exactly, the load forwards from the youngest of them.
- R5: A load whose byte range overlaps an older unsent store but differs in address or size gets no forwarded result. It waits until that store is sent, then reads memory (`wb_fwd`=0). A load with no overlap also reads memory.
- R6: A load does not issue and does not forward while any older store still has an unknown address.
- R7: A load with a known address may issue to memory ahead of an older load whose address is still unknown.
- R8: A store with a known address may issue to memory ahead of an older load whose address is still unknown.
- R9: Stores issue to memory strictly in program order. A store whose address is known waits behind an older store whose address is unknown.
- R10: `flush_valid` with `flush_tag` discards every entry younger than `flush_tag`, and the next allocation reuses the slot after `flush_tag`. A discarded load with an outstanding memory request never writes back, and its slot cannot be allocated until that response has come back.
- R11: Among eligible operations the oldest is requested. A memory response writes back its data with `wb_fwd`=0 and takes the writeback port ahead of a pending forward, which follows on a later cycle.
- R12: Entries retire from the head once complete: a store when memory accepts it, a load when its result has been written back. The queue returns to empty after all operations finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate one operation this cycle |
| alloc_is_st | input | 1 | 1 = store, 0 = load |
| alloc_size | input | 2 | Access size code, 2^code bytes |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | 4 | Tag (slot) given to the allocated operation |
| addr_valid | input | 1 | Address (and store data) delivery |
| addr_tag | input | 4 | Tag the address belongs to |
| addr_value | input | 16 | Byte address |
| addr_data | input | 64 | Store data (ignored for loads) |
| flush_valid | input | 1 | Discard entries younger than flush_tag |
| flush_tag | input | 4 | Youngest surviving tag |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_is_st | output | 1 | Request is a store |
| mem_req_size | output | 2 | Request size code |
| mem_req_addr | output | 16 | Request address |
| mem_req_data | output | 64 | Store data |
| mem_req_tag | output | 4 | Request tag |
| mem_rsp_valid | input | 1 | Load data returning from memory |
| mem_rsp_tag | input | 4 | Tag of the returning load |
| mem_rsp_data | input | 64 | Returned data |
| wb_valid | output | 1 | Load result writeback |
| wb_tag | output | 4 | Tag of the written-back load |
| wb_data | output | 64 | Load result |
| wb_fwd | output | 1 | Result came from a queued store |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slots occupied |

## Verification
The in-line assertions check several properties on every cycle. The queue never offers allocation while full, and it never holds more than DEPTH entries. Every memory request names a live entry with a known address that has not been sent. Every forwarded writeback targets a live load. A response for a discarded load never reaches the writeback port. A sequence stamp on each entry lets them confirm that accepted stores come out in allocation order. Only the bench scenarios can show the data side: exact versus partial matches, the youngest-match choice, loads and stores passing blocked loads, and the trimmed tail being reused.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    parameter int LSQ_AW = 16;
    parameter int LSQ_DW = 64;

    typedef logic [1:0] lsq_size_t;

    typedef struct packed {
        logic              valid;
        logic              is_st;
        lsq_size_t         size;
        logic              addr_ok;
        logic [LSQ_AW-1:0] addr;
        logic [LSQ_DW-1:0] data;
        logic              issued;
        logic              done;
    } lsq_ent_t;

    // one past the last byte touched
    function automatic logic [LSQ_AW:0] lsq_end(input logic [LSQ_AW-1:0] a, input lsq_size_t s);
        return {1'b0, a} + ((LSQ_AW+1)'(1) << s);
    endfunction

    function automatic logic lsq_overlap(input logic [LSQ_AW-1:0] a, input lsq_size_t sa,
                                         input logic [LSQ_AW-1:0] b, input lsq_size_t sb);
        return ({1'b0, a} < lsq_end(b, sb)) && ({1'b0, b} < lsq_end(a, sa));
    endfunction

    function automatic logic [LSQ_DW-1:0] lsq_mask(input lsq_size_t s);
        logic [LSQ_DW-1:0] m;
        m = '0;
        for (int b = 0; b < LSQ_DW; b++)
            if (b < (8 << s)) m[b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/lsq_oldest.sv
// Picks the oldest requesting slot, age measured from head. DEPTH must be a power of two.
module lsq_oldest #(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [PW-1:0]    head,
    output logic             found,
    output logic [PW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [PW-1:0] j;
            j = head + PW'(k);
            if (req[j]) begin
                found = 1'b1;
                idx   = j;
            end
        end
    end
endmodule

// File: rtl/lsq_hazard.sv
// Ordering and forwarding decision for one slot against all older slots.
module lsq_hazard
    import lsq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int IDX   = 0
) (
    input  lsq_ent_t          ents [DEPTH],
    input  logic [PW-1:0]     head,
    output logic              ld_mem_ok,
    output logic              ld_fwd_ok,
    output logic              st_ok,
    output logic [LSQ_DW-1:0] fwd_data
);
    lsq_ent_t          self;
    logic [PW-1:0]     my_age;
    logic              unk, st_pend, hit, exact, base;
    logic [LSQ_DW-1:0] hdata;

    always_comb begin
        self    = ents[IDX];
        my_age  = PW'(IDX) - head;
        unk     = 1'b0;
        st_pend = 1'b0;
        hit     = 1'b0;
        exact   = 1'b0;
        hdata   = '0;
        // oldest to youngest, so the last hit recorded is the youngest match
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW-1:0] j;
            j = head + PW'(k);
            if (PW'(k) < my_age && ents[j].valid && ents[j].is_st) begin
                if (!ents[j].addr_ok) unk = 1'b1;
                if (!ents[j].issued) begin
                    st_pend = 1'b1;
                    if (ents[j].addr_ok &&
                        lsq_overlap(ents[j].addr, ents[j].size, self.addr, self.size)) begin
                        hit   = 1'b1;
                        exact = (ents[j].addr == self.addr) && (ents[j].size == self.size);
                        hdata = ents[j].data;
                    end
                end
            end
        end
        base      = self.valid && self.addr_ok && !self.issued;
        st_ok     = base && self.is_st && !st_pend;
        ld_mem_ok = base && !self.is_st && !unk && !hit;
        ld_fwd_ok = base && !self.is_st && !unk && hit && exact;
        fwd_data  = hdata & lsq_mask(self.size);
    end
endmodule

// File: rtl/lsq_core.sv
module lsq_core
    import lsq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_is_st,
    input  logic [1:0]        alloc_size,
    output logic              alloc_ready,
    output logic [PW-1:0]     alloc_tag,
    input  logic              addr_valid,
    input  logic [PW-1:0]     addr_tag,
    input  logic [LSQ_AW-1:0] addr_value,
    input  logic [LSQ_DW-1:0] addr_data,
    input  logic              flush_valid,
    input  logic [PW-1:0]     flush_tag,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_is_st,
    output logic [1:0]        mem_req_size,
    output logic [LSQ_AW-1:0] mem_req_addr,
    output logic [LSQ_DW-1:0] mem_req_data,
    output logic [PW-1:0]     mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [PW-1:0]     mem_rsp_tag,
    input  logic [LSQ_DW-1:0] mem_rsp_data,
    output logic              wb_valid,
    output logic [PW-1:0]     wb_tag,
    output logic [LSQ_DW-1:0] wb_data,
    output logic              wb_fwd,
    output logic              full,
    output logic              empty
);
    localparam int CW = PW + 1;

    lsq_ent_t          ents   [DEPTH];
    lsq_ent_t          ents_n [DEPTH];
    logic [PW-1:0]     head, tail, head_n, tail_n;
    logic [CW-1:0]     count, count_n;
    logic [DEPTH-1:0]  orphan, orphan_n;

    logic [DEPTH-1:0]  ld_mem_ok_v, ld_fwd_ok_v, st_ok_v, kill;
    logic [LSQ_DW-1:0] fwd_data_a [DEPTH];
    logic              iss_found, fwd_found, fwd_fire, rsp_live, alloc_fire, retire;
    logic [PW-1:0]     iss_idx, fwd_idx, keep_age;

    for (genvar g = 0; g < DEPTH; g++) begin : g_haz
        lsq_hazard #(.DEPTH(DEPTH), .PW(PW), .IDX(g)) u_haz (
            .ents      (ents),
            .head      (head),
            .ld_mem_ok (ld_mem_ok_v[g]),
            .ld_fwd_ok (ld_fwd_ok_v[g]),
            .st_ok     (st_ok_v[g]),
            .fwd_data  (fwd_data_a[g])
        );
        assign kill[g] = flush_valid && ((PW'(g) - head) > keep_age);
    end

    assign keep_age = flush_tag - head;

    lsq_oldest #(.DEPTH(DEPTH), .PW(PW)) u_pick_mem (
        .req   ((ld_mem_ok_v | st_ok_v) & ~kill),
        .head  (head),
        .found (iss_found),
        .idx   (iss_idx)
    );

    lsq_oldest #(.DEPTH(DEPTH), .PW(PW)) u_pick_fwd (
        .req   (ld_fwd_ok_v & ~kill),
        .head  (head),
        .found (fwd_found),
        .idx   (fwd_idx)
    );

    assign full          = (count == CW'(DEPTH));
    assign empty         = (count == '0);
    assign alloc_tag     = tail;
    assign alloc_ready   = !full && !orphan[tail] && !flush_valid;
    assign alloc_fire    = alloc_valid && alloc_ready;
    assign retire        = !empty && ents[head].done && !flush_valid;

    assign mem_req_valid = iss_found;
    assign mem_req_tag   = iss_idx;
    assign mem_req_is_st = ents[iss_idx].is_st;
    assign mem_req_size  = ents[iss_idx].size;
    assign mem_req_addr  = ents[iss_idx].addr;
    assign mem_req_data  = ents[iss_idx].data;

    assign rsp_live = mem_rsp_valid && !orphan[mem_rsp_tag] && !kill[mem_rsp_tag]
                      && ents[mem_rsp_tag].valid;
    assign fwd_fire = fwd_found && !mem_rsp_valid;
    assign wb_valid = rsp_live || fwd_fire;
    assign wb_tag   = rsp_live ? mem_rsp_tag : fwd_idx;
    assign wb_data  = rsp_live ? mem_rsp_data : fwd_data_a[fwd_idx];
    assign wb_fwd   = !rsp_live && fwd_fire;

    always_comb begin
        ents_n   = ents;
        orphan_n = orphan;
        if (addr_valid && ents[addr_tag].valid) begin
            ents_n[addr_tag].addr_ok = 1'b1;
            ents_n[addr_tag].addr    = addr_value;
            if (ents[addr_tag].is_st) ents_n[addr_tag].data = addr_data;
        end
        if (mem_req_valid && mem_req_ready) begin
            ents_n[iss_idx].issued = 1'b1;
            if (ents[iss_idx].is_st) ents_n[iss_idx].done = 1'b1;
        end
        if (mem_rsp_valid) begin
            if (orphan[mem_rsp_tag]) orphan_n[mem_rsp_tag] = 1'b0;
            else if (ents[mem_rsp_tag].valid) ents_n[mem_rsp_tag].done = 1'b1;
        end
        if (fwd_fire) begin
            ents_n[fwd_idx].issued = 1'b1;
            ents_n[fwd_idx].done   = 1'b1;
        end
        if (retire) ents_n[head] = '0;
        if (alloc_fire) begin
            ents_n[tail]       = '0;
            ents_n[tail].valid = 1'b1;
            ents_n[tail].is_st = alloc_is_st;
            ents_n[tail].size  = alloc_size;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (kill[i]) begin
                if (ents_n[i].valid && !ents_n[i].is_st && ents_n[i].issued && !ents_n[i].done)
                    orphan_n[i] = 1'b1;
                ents_n[i] = '0;
            end
        end
        head_n = head + PW'(retire);
        if (flush_valid) begin
            tail_n  = flush_tag + PW'(1);
            count_n = CW'(keep_age) + CW'(1);
        end else begin
            tail_n  = tail + PW'(alloc_fire);
            count_n = count + CW'(alloc_fire) - CW'(retire);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            orphan <= '0;
            head   <= '0;
            tail   <= '0;
            count  <= '0;
        end else begin
            ents   <= ents_n;
            orphan <= orphan_n;
            head   <= head_n;
            tail   <= tail_n;
            count  <= count_n;
        end
    end

    // allocation stamps, kept only for the store-order property
    logic [31:0] seq_ctr, last_st_seq;
    logic [31:0] seq [DEPTH];
    logic        have_st;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_ctr     <= '0;
            last_st_seq <= '0;
            have_st     <= 1'b0;
            for (int i = 0; i < DEPTH; i++) seq[i] <= '0;
        end else begin
            if (alloc_fire) begin
                seq[tail] <= seq_ctr;
                seq_ctr   <= seq_ctr + 32'd1;
            end
            if (mem_req_valid && mem_req_ready && mem_req_is_st) begin
                last_st_seq <= seq[mem_req_tag];
                have_st     <= 1'b1;
            end
        end
    end

    a_r2_no_alloc_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_ready);

    a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r9_store_order: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && mem_req_is_st && have_st)
        |-> (seq[mem_req_tag] > last_st_seq));

    a_r11_req_live: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (ents[mem_req_tag].valid && ents[mem_req_tag].addr_ok
                           && !ents[mem_req_tag].issued));

    a_r3_fwd_target: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_fwd) |-> (ents[wb_tag].valid && !ents[wb_tag].is_st
                                  && ents[wb_tag].addr_ok));

    a_r10_orphan_silent: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && orphan[mem_rsp_tag]) |-> !wb_valid);

endmodule

// File: tb/sim_lsq_core.sv
module sim_lsq_core;
    import lsq_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              alloc_valid, alloc_is_st, alloc_ready;
    logic [1:0]        alloc_size;
    logic [3:0]        alloc_tag;
    logic              addr_valid;
    logic [3:0]        addr_tag;
    logic [15:0]       addr_value;
    logic [63:0]       addr_data;
    logic              flush_valid;
    logic [3:0]        flush_tag;
    logic              mem_req_valid, mem_req_ready, mem_req_is_st;
    logic [1:0]        mem_req_size;
    logic [15:0]       mem_req_addr;
    logic [63:0]       mem_req_data;
    logic [3:0]        mem_req_tag;
    logic              mem_rsp_valid;
    logic [3:0]        mem_rsp_tag;
    logic [63:0]       mem_rsp_data;
    logic              wb_valid, wb_fwd, full, empty;
    logic [3:0]        wb_tag;
    logic [63:0]       wb_data;

    always #5 clk = ~clk;

    lsq_core u0 (.*);

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct packed {
        logic [15:0] sa;
        logic [1:0]  ss;
        logic [63:0] sd;
        logic [15:0] la;
        logic [1:0]  ls;
        logic        fwd;
        logic [63:0] ed;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{16'h0100, 2'd3, 64'h1122334455667788, 16'h0100, 2'd3, 1'b1, 64'h1122334455667788},
        '{16'h0100, 2'd2, 64'h1122334455667788, 16'h0100, 2'd2, 1'b1, 64'h0000000055667788},
        '{16'h0200, 2'd0, 64'hFFFFFFFFFFFFFF5A, 16'h0200, 2'd0, 1'b1, 64'h000000000000005A},
        '{16'h0100, 2'd3, 64'h0102030405060708, 16'h0104, 2'd2, 1'b0, 64'h0},
        '{16'h0100, 2'd2, 64'h0102030405060708, 16'h0100, 2'd3, 1'b0, 64'h0},
        '{16'h0300, 2'd1, 64'h0000000000001234, 16'h0308, 2'd1, 1'b0, 64'h0}
    };

    function automatic logic [63:0] memv(input logic [15:0] a);
        return 64'hA5A5_0000_0000_0000 | 64'(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_is_st = 0; alloc_size = 0;
        addr_valid = 0; addr_tag = 0; addr_value = 0; addr_data = 0;
        flush_valid = 0; flush_tag = 0; mem_req_ready = 0;
        mem_rsp_valid = 0; mem_rsp_tag = 0; mem_rsp_data = 0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        step(); step();
        rst = 0;
        step();
    endtask

    task automatic alloc(input bit st, input logic [1:0] sz, output logic [3:0] tag);
        alloc_valid = 1; alloc_is_st = st; alloc_size = sz;
        #1 tag = alloc_tag;
        step();
        alloc_valid = 0;
    endtask

    task automatic give_addr(input logic [3:0] tag, input logic [15:0] a, input logic [63:0] d);
        addr_valid = 1; addr_tag = tag; addr_value = a; addr_data = d;
        step();
        addr_valid = 0;
    endtask

    // memory answers each accepted load one cycle later
    task automatic drain(output int nwb, output logic [63:0] lastd, output bit lastf);
        bit          pend = 0, npend;
        logic [3:0]  ptag = 0, ntag;
        logic [63:0] pdata = 0, ndata;
        nwb = 0; lastd = 0; lastf = 0;
        mem_req_ready = 1;
        for (int c = 0; c < 100; c++) begin
            mem_rsp_valid = pend; mem_rsp_tag = ptag; mem_rsp_data = pdata;
            #1;
            if (wb_valid) begin
                nwb++; lastd = wb_data; lastf = wb_fwd;
            end
            npend = mem_req_valid && !mem_req_is_st;
            ntag  = mem_req_tag;
            ndata = memv(mem_req_addr);
            step();
            pend = npend; ptag = ntag; pdata = ndata;
            if (empty && !pend) break;
        end
        mem_rsp_valid = 0;
        mem_req_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 64'd1, 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [3:0]  ts, tl, t0, t1, t2;
        int          nwb;
        logic [63:0] ld;
        bit          lf;

        do_reset();
        #1;
        chk(empty && !full && alloc_ready, "R1 reset flags", {61'd0, empty, full, alloc_ready}, 64'h5);
        chk(!mem_req_valid && !wb_valid, "R1 reset outputs", {62'd0, mem_req_valid, wb_valid}, 64'h0);
        step();

        // table: one store then one load, memory stalled while the pair is examined
        for (int r = 0; r < 6; r++) begin
            alloc(1, ROWS[r].ss, ts);
            alloc(0, ROWS[r].ls, tl);
            give_addr(ts, ROWS[r].sa, ROWS[r].sd);
            give_addr(tl, ROWS[r].la, 64'h0);
            #1;
            if (ROWS[r].fwd) begin
                chk(wb_valid && wb_fwd && wb_tag == tl, "R3 forward taken", {59'd0, wb_valid, wb_fwd, wb_tag}, {59'd0, 2'b11, tl});
                chk(wb_data == ROWS[r].ed, "R3 forward data", wb_data, ROWS[r].ed);
            end else begin
                chk(!wb_valid, "R5 no forward on mismatch", 64'(wb_valid), 64'd0);
                chk(mem_req_valid && mem_req_tag == ts, "R11 oldest requested", 64'(mem_req_tag), 64'(ts));
            end
            step();
            drain(nwb, ld, lf);
            if (ROWS[r].fwd)
                chk(nwb == 0, "R3 no memory result after forward", 64'(nwb), 64'd0);
            else
                chk(nwb == 1 && ld == memv(ROWS[r].la) && !lf, "R5 load reads memory", ld, memv(ROWS[r].la));
            chk(empty, "R12 drained to empty", 64'(empty), 64'd1);
        end

        // R2: fill, attempt overflow, then drain
        do_reset();
        for (int k = 0; k < 16; k++) begin
            alloc(0, 2'd3, t0);
            chk(t0 == 4'(k), "R2 sequential tag", 64'(t0), 64'(k));
        end
        #1 chk(full && !alloc_ready, "R2 full stalls", {62'd0, full, alloc_ready}, 64'h2);
        alloc_valid = 1; alloc_is_st = 0;
        step();
        alloc_valid = 0;
        for (int k = 0; k < 16; k++) give_addr(4'(k), 16'(k * 8), 64'h0);
        drain(nwb, ld, lf);
        chk(nwb == 16, "R2 overflow allocation ignored", 64'(nwb), 64'd16);
        chk(empty, "R12 all retired", 64'(empty), 64'd1);

        // R4: youngest of two matching stores
        do_reset();
        alloc(1, 2'd3, t0); alloc(1, 2'd3, t1); alloc(0, 2'd3, t2);
        give_addr(t0, 16'h0040, 64'hAAAA_AAAA_AAAA_AAAA);
        give_addr(t1, 16'h0040, 64'hBBBB_BBBB_BBBB_BBBB);
        give_addr(t2, 16'h0040, 64'h0);
        #1 chk(wb_valid && wb_tag == t2 && wb_data == 64'hBBBB_BBBB_BBBB_BBBB, "R4 youngest match", wb_data, 64'hBBBB_BBBB_BBBB_BBBB);
        step();
        drain(nwb, ld, lf);

        // R6 / R9: unknown older store address blocks the load and the younger store
        do_reset();
        alloc(1, 2'd3, t0); alloc(1, 2'd3, t1); alloc(0, 2'd3, t2);
        give_addr(t1, 16'h0030, 64'h33);
        give_addr(t2, 16'h0080, 64'h0);
        #1;
        chk(!mem_req_valid, "R6 R9 blocked by unknown store address", 64'(mem_req_valid), 64'd0);
        chk(!wb_valid, "R6 no forward while blocked", 64'(wb_valid), 64'd0);
        step();
        give_addr(t0, 16'h0090, 64'h99);
        #1 chk(mem_req_valid && mem_req_is_st && mem_req_tag == t0, "R9 first store first", 64'(mem_req_tag), 64'(t0));
        mem_req_ready = 1;
        step();
        #1 chk(mem_req_valid && mem_req_is_st && mem_req_tag == t1, "R9 second store next", 64'(mem_req_tag), 64'(t1));
        mem_req_ready = 0;
        step();
        drain(nwb, ld, lf);
        chk(nwb == 1 && ld == memv(16'h0080), "R6 load completes later", ld, memv(16'h0080));

        // R7: younger load passes an older load of unknown address
        do_reset();
        alloc(0, 2'd3, t0); alloc(0, 2'd3, t1);
        give_addr(t1, 16'h0010, 64'h0);
        #1 chk(mem_req_valid && !mem_req_is_st && mem_req_tag == t1, "R7 load passes load", 64'(mem_req_tag), 64'(t1));
        step();
        give_addr(t0, 16'h0018, 64'h0);
        drain(nwb, ld, lf);
        chk(nwb == 2, "R7 both loads complete", 64'(nwb), 64'd2);

        // R8: store passes an older load of unknown address
        do_reset();
        alloc(0, 2'd3, t0); alloc(1, 2'd3, t1);
        give_addr(t1, 16'h0020, 64'h77);
        #1 chk(mem_req_valid && mem_req_is_st && mem_req_tag == t1, "R8 store passes load", 64'(mem_req_tag), 64'(t1));
        step();
        give_addr(t0, 16'h0028, 64'h0);
        drain(nwb, ld, lf);

        // R10: trim the tail while a younger load is outstanding
        do_reset();
        alloc(0, 2'd3, t0); alloc(0, 2'd3, t1); alloc(0, 2'd3, t2);
        give_addr(t0, 16'h0010, 64'h0);
        give_addr(t1, 16'h0020, 64'h0);
        give_addr(t2, 16'h0030, 64'h0);
        mem_req_ready = 1;
        #1 chk(mem_req_tag == t0, "R11 oldest load first", 64'(mem_req_tag), 64'(t0));
        step();
        #1 chk(mem_req_tag == t1, "R11 next load", 64'(mem_req_tag), 64'(t1));
        step();
        mem_req_ready = 0; flush_valid = 1; flush_tag = t0;
        step();
        flush_valid = 0;
        #1;
        chk(!alloc_ready && !empty, "R10 orphan slot blocks allocation", {62'd0, alloc_ready, empty}, 64'd0);
        chk(!mem_req_valid, "R10 discarded load not requested", 64'(mem_req_valid), 64'd0);
        mem_rsp_valid = 1; mem_rsp_tag = t1; mem_rsp_data = memv(16'h0020);
        #1 chk(!wb_valid, "R10 discarded load silent", 64'(wb_valid), 64'd0);
        step();
        mem_rsp_tag = t0; mem_rsp_data = memv(16'h0010);
        #1 chk(wb_valid && wb_tag == t0 && wb_data == memv(16'h0010), "R10 survivor writes back", wb_data, memv(16'h0010));
        step();
        mem_rsp_valid = 0;
        #1 chk(alloc_ready, "R10 slot free after response", 64'(alloc_ready), 64'd1);
        alloc(0, 2'd3, t1);
        chk(t1 == 4'd1, "R10 tail trimmed", 64'(t1), 64'd1);
        give_addr(t1, 16'h0040, 64'h0);
        drain(nwb, ld, lf);
        chk(nwb == 1 && empty, "R10 reuse completes", 64'(nwb), 64'd1);

        // R11: memory response wins the writeback port over a forward
        do_reset();
        alloc(0, 2'd3, t0);
        give_addr(t0, 16'h0010, 64'h0);
        mem_req_ready = 1;
        step();
        mem_req_ready = 0;
        alloc(1, 2'd3, t1); alloc(0, 2'd3, t2);
        give_addr(t1, 16'h0050, 64'hDEAD_BEEF_0123_4567);
        give_addr(t2, 16'h0050, 64'h0);
        mem_rsp_valid = 1; mem_rsp_tag = t0; mem_rsp_data = memv(16'h0010);
        #1 chk(wb_valid && !wb_fwd && wb_tag == t0 && wb_data == memv(16'h0010), "R11 response first", wb_data, memv(16'h0010));
        step();
        mem_rsp_valid = 0;
        #1 chk(wb_valid && wb_fwd && wb_tag == t2 && wb_data == 64'hDEAD_BEEF_0123_4567, "R11 forward follows", wb_data, 64'hDEAD_BEEF_0123_4567);
        step();
        drain(nwb, ld, lf);
        chk(nwb == 0 && empty, "R12 store retires after acceptance", 64'(nwb), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule